// File: doc/BRIEF.md
# Calendar Access Sequencer

This block sits above a serial nibble-transfer master and turns one request into a complete time-of-day read or write on an external clock peripheral. The peripheral stores every calendar field as two 4-bit BCD registers. The sequencer drives the peripheral's chip enable. Before each access it runs a busy handshake: it rewrites the control register and polls its busy flag, and it drops chip enable for a fixed gap between attempts. After the handshake it walks the field registers in a fixed order. On a read it packs each pair of nibbles into one BCD byte. On a write it splits each byte into two nibbles.

After reset the block checks once whether the peripheral's oscillator stopped. If the stop flag is set, it clears the interrupt interval register, starts the adjust sequence, waits until the busy flag clears, and then writes a default date of 00:00:00, day 01, month 01, year 00, weekday 0. A retry counter limits every busy poll. When the counter runs out, the operation ends with an error flag and no field transfers.

The time bus is packed as `{weekday[3:0], year, month, day, hour, minute, second}`, with seconds in bits 7:0 and the weekday nibble in bits 51:48.

Top module: `cal_seq`

## Requirements
- R1: While reset is asserted, `ce`, `xfer_req`, `done` and `err` are 0, `rtime` is 0 and `busy` is 1.
- R2: After reset the block reads control register 0xE once. If bit 1 of that value is clear, it makes no write, returns to idle (`busy` low) and does not pulse `done`.
- R3: If bit 1 of that start-up read is set, the block writes 0x0 to register 0x7, then writes 0x7 to register 0xE, then polls register 0xE until bit 0 is clear. It then performs a normal write of the default date, which leaves every field nibble 0 except day units (0x8) and month units (0xA), which become 1.
- R4: Every access begins by writing 0x4 to register 0xE and then reading 0xE. If bit 0 is set, `ce` goes low for at least GAP_NS of clock time, and the write and read are repeated.
- R5: Field transfers use the register addresses 0x0,0x1,0x2,0x3,0x4,0x5,0x8,0x9,0xA,0xB,0xC,0xD,0x6 in that order: units before tens for seconds, minutes, hours, day, month and year, then the single weekday nibble.
- R6: A read returns each byte as (tens nibble << 4) | units nibble in `rtime`, with the weekday nibble in bits 51:48.
- R7: A write sends the low nibble of each `wtime` byte to the units address and the high nibble to the tens address, and sends `wtime[51:48]` to 0x6.
- R8: After the last transfer, `ce` stays low for at least GAP_NS before `done` pulses for exactly one cycle.
- R9: After MAX_TRIES consecutive busy reads with bit 0 set, the operation makes no field transfer and ends with `done` and `err` both high. `err` clears when the next request is accepted. MAX_TRIES-1 busy reads still let the operation succeed.
- R10: Requests are accepted only while idle and are ignored while `busy` is high. If `rd_req` and `wr_req` arrive together, the read is performed.
- R11: `xfer_req` is only high while `ce` is high. Once raised, it holds its address, direction and data until `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Start a full time read (pulse) |
| wr_req | input | 1 | Start a full time write (pulse) |
| wtime | input | 52 | Packed BCD time to write, sampled when the request is accepted |
| rtime | output | 52 | Packed BCD time from the last successful read |
| busy | output | 1 | High while start-up or an operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| err | output | 1 | Busy retry limit reached in the last operation |
| ce | output | 1 | Peripheral chip enable |
| xfer_req | output | 1 | Nibble transfer request to the serial master |
| xfer_wr | output | 1 | 1 = register write, 0 = register read |
| xfer_addr | output | 4 | Peripheral register address |
| xfer_wdata | output | 4 | Nibble to write |
| xfer_ack | input | 1 | Transfer complete, held high for one cycle |
| xfer_rdata | input | 4 | Nibble read, valid with xfer_ack |

## Verification
A set of packed times runs through a write and then a read-back. The set includes all-nines digits, the smallest legal date, and values whose tens and units nibbles differ. Checking the peripheral's register image after each write separates a correct split from swapped nibbles or swapped addresses, which a round trip alone would hide. A read from a preloaded register image separates a correct assembly from a mirror-image error. Busy patterns of zero, three, MAX_TRIES-1 and MAX_TRIES set reads separate the normal path, the retry path with its chip-enable gaps, the last retry that still succeeds, and the error exit. Start-up runs once with the stop flag clear and once with it set.

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int CLK_NS    = 8,
  parameter int GAP_NS    = 700,
  parameter int MAX_TRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic [51:0] wtime,
  output logic [51:0] rtime,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        ce,
  output logic        xfer_req,
  output logic        xfer_wr,
  output logic [3:0]  xfer_addr,
  output logic [3:0]  xfer_wdata,
  input  logic        xfer_ack,
  input  logic [3:0]  xfer_rdata
);

  localparam int GAP_CYC = (GAP_NS + CLK_NS - 1) / CLK_NS;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int TW      = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [3:0] A_CTL  = 4'hE;
  localparam logic [3:0] A_INTV = 4'h7;
  localparam logic [3:0] LAST   = 4'd12;
  localparam logic [51:0] DEF_TIME = 52'h0_00_01_01_00_00_00;

  typedef enum logic [3:0] {
    S_BOOT, S_PCHK, S_PINT, S_PCTL, S_PPOLL, S_IDLE,
    S_BWR, S_BRD, S_BGAP, S_FLD, S_EGAP, S_DONE
  } st_t;

  st_t         st;
  logic        op_wr, boot, abort;
  logic [TW-1:0] tries;
  logic [GW-1:0] gcnt;
  logic [3:0]  idx;
  logic [51:0] shadow, rtime_q;
  logic        err_q;
  logic [3:0]  fld_addr;
  logic        busy_bit, last_try, gap_end;

  assign busy_bit = xfer_rdata[0];
  assign last_try = (tries == TW'(MAX_TRIES - 1));
  assign gap_end  = (gcnt == GW'(GAP_CYC - 1));

  assign fld_addr = (idx == LAST) ? 4'h6 :
                    (idx[3:1] < 3'd3) ? idx : idx + 4'd2;

  assign ce = (st == S_PCHK) || (st == S_PINT) || (st == S_PCTL) ||
              (st == S_PPOLL) || (st == S_BWR) || (st == S_BRD) ||
              (st == S_FLD);
  assign busy  = (st != S_IDLE);
  assign done  = (st == S_DONE);
  assign err   = err_q;
  assign rtime = rtime_q;

  always_comb begin
    xfer_req   = 1'b1;
    xfer_wr    = 1'b0;
    xfer_addr  = A_CTL;
    xfer_wdata = 4'h0;
    case (st)
      S_PCHK, S_PPOLL, S_BRD: ;
      S_PINT: begin
        xfer_wr   = 1'b1;
        xfer_addr = A_INTV;
      end
      S_PCTL: begin
        xfer_wr    = 1'b1;
        xfer_wdata = 4'h7;
      end
      S_BWR: begin
        xfer_wr    = 1'b1;
        xfer_wdata = 4'h4;
      end
      S_FLD: begin
        xfer_wr    = op_wr;
        xfer_addr  = fld_addr;
        xfer_wdata = shadow[{idx, 2'b00} +: 4];
      end
      default: xfer_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_BOOT;
      op_wr   <= 1'b0;
      boot    <= 1'b1;
      abort   <= 1'b0;
      tries   <= '0;
      gcnt    <= '0;
      idx     <= '0;
      shadow  <= '0;
      rtime_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_BOOT: st <= S_PCHK;
        S_PCHK: if (xfer_ack) begin
          gcnt <= '0;
          st   <= xfer_rdata[1] ? S_PINT : S_EGAP;
        end
        S_PINT: if (xfer_ack) st <= S_PCTL;
        S_PCTL: if (xfer_ack) begin
          tries <= '0;
          st    <= S_PPOLL;
        end
        S_PPOLL: if (xfer_ack) begin
          if (busy_bit) begin
            if (last_try) begin
              abort <= 1'b1;
              gcnt  <= '0;
              st    <= S_EGAP;
            end else begin
              tries <= tries + 1'b1;
            end
          end else begin
            shadow <= DEF_TIME;
            op_wr  <= 1'b1;
            tries  <= '0;
            st     <= S_BWR;
          end
        end
        S_IDLE: begin
          if (rd_req || wr_req) begin
            op_wr <= !rd_req;
            tries <= '0;
            abort <= 1'b0;
            err_q <= 1'b0;
            st    <= S_BWR;
            if (!rd_req) shadow <= wtime;
          end
        end
        S_BWR: if (xfer_ack) st <= S_BRD;
        S_BRD: if (xfer_ack) begin
          gcnt <= '0;
          if (busy_bit) begin
            if (last_try) begin
              abort <= 1'b1;
              st    <= S_EGAP;
            end else begin
              tries <= tries + 1'b1;
              st    <= S_BGAP;
            end
          end else begin
            idx <= '0;
            st  <= S_FLD;
          end
        end
        S_BGAP: begin
          gcnt <= gcnt + 1'b1;
          if (gap_end) st <= S_BWR;
        end
        S_FLD: if (xfer_ack) begin
          if (!op_wr) shadow[{idx, 2'b00} +: 4] <= xfer_rdata;
          if (idx == LAST) begin
            gcnt <= '0;
            st   <= S_EGAP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_EGAP: begin
          gcnt <= gcnt + 1'b1;
          if (gap_end) begin
            boot <= 1'b0;
            if (boot && !abort) begin
              st <= S_IDLE;
            end else begin
              err_q <= abort;
              if (!op_wr && !abort) rtime_q <= shadow;
              st <= S_DONE;
            end
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [GW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) low_cnt <= GW'(GAP_CYC);
    else if (ce) low_cnt <= '0;
    else if (low_cnt != GW'(GAP_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  // R11
  req_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> ce);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_addr) &&
                                 $stable(xfer_wr) && $stable(xfer_wdata)));

  // R4
  ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce) |-> (low_cnt >= GW'(GAP_CYC)));

  // R8
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ce && low_cnt >= GW'(GAP_CYC)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

endmodule

// File: tb/cal_seq_test.sv
module cal_seq_test;
  localparam int GAP = 88;
  localparam int LAT = 3;
  localparam int MAXT = 8;

  logic clk = 0, rst_n = 0, rd_req = 0, wr_req = 0;
  logic [51:0] wtime = '0, rtime;
  logic busy, done, err, ce, xfer_req, xfer_wr, xfer_ack = 0;
  logic [3:0] xfer_addr, xfer_wdata, xfer_rdata = 0;

  cal_seq uut (.clk, .rst_n, .rd_req, .wr_req, .wtime, .rtime, .busy, .done,
               .err, .ce, .xfer_req, .xfer_wr, .xfer_addr, .xfer_wdata,
               .xfer_ack, .xfer_rdata);

  always #4 clk = ~clk;

  int errs = 0, checks = 0;
  logic [3:0] mem [16];
  logic xstp = 0;
  int busy_left = 0;
  logic [3:0] log_a [64];
  logic       log_w [64];
  logic [3:0] log_d [64];
  int log_n = 0;
  int lowrun = 0, min_low = 1000000, low_at_done = 0;

  localparam logic [51:0] VEC [4] = '{
    52'h3_99_12_31_23_59_58, 52'h0_00_01_01_00_00_00,
    52'h6_47_07_15_12_34_56, 52'h5_25_10_09_19_08_07 };
  localparam logic [3:0] ORD [13] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5,
    4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'h6};

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // peripheral model behind the serial master
  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || xfer_ack) begin
        xfer_ack = 0;
        wc = 0;
      end else if (xfer_req) begin
        wc++;
        if (wc >= LAT) begin
          wc = 0;
          xfer_ack = 1;
          if (log_n < 64) begin
            log_a[log_n] = xfer_addr;
            log_w[log_n] = xfer_wr;
            log_d[log_n] = xfer_wdata;
            log_n++;
          end
          if (xfer_wr) begin
            mem[xfer_addr] = xfer_wdata;
            if (xfer_addr == 4'hE && xfer_wdata == 4'h7) xstp = 0;
          end else if (xfer_addr == 4'hE) begin
            xfer_rdata = {mem[14][3:2], xstp, busy_left > 0};
            if (busy_left > 0) busy_left--;
          end else begin
            xfer_rdata = mem[xfer_addr];
          end
        end
      end else wc = 0;
    end
  end

  // chip-enable low-time monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) lowrun = 0;
      else if (!ce) begin
        lowrun++;
        if (done) low_at_done = lowrun;
      end else begin
        if (lowrun > 0 && lowrun < min_low) min_low = lowrun;
        lowrun = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic run_op(input bit rd, input bit wr, output bit got_done);
    got_done = 0;
    log_n = 0;
    min_low = 1000000;
    @(negedge clk);
    rd_req = rd; wr_req = wr;
    @(negedge clk);
    rd_req = 0; wr_req = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin got_done = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  int nfield, nctl4;
  bit gd;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 4'(i ^ 5);
    xstp = 0; busy_left = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ce && !xfer_req && !done && !err, "R1 outputs in reset",
        {ce, xfer_req, done, err}, 0);
    chk(rtime == 0 && busy, "R1 rtime/busy in reset", rtime, 0);
    log_n = 0;
    rst_n = 1;
    wait_idle();
    // R2 no flag: only one control read, no write
    chk(log_n == 1 && !log_w[0] && log_a[0] == 4'hE, "R2 boot transfers",
        log_n, 1);
    chk(mem[8] == 4'hD && mem[7] == 4'h2, "R2 registers untouched",
        {mem[8], mem[7]}, 8'hD2);

    // table of write/read-back vectors (R5, R6, R7)
    for (int v = 0; v < 4; v++) begin
      wtime = VEC[v];
      run_op(0, 1, gd);
      chk(gd && !err, "R7 write completes", {gd, err}, 2'b10);
      nfield = 0;
      for (int k = 0; k < 13; k++)
        if (mem[ORD[k]] != VEC[v][4*k +: 4]) nfield++;
      chk(nfield == 0, "R7 nibble split", nfield, 0);
      nfield = 0;
      for (int k = 0; k < 13; k++)
        if (log_a[k + 2] != ORD[k] || !log_w[k + 2]) nfield++;
      chk(log_n == 15 && nfield == 0, "R5 write order", nfield, 0);
      chk(log_a[0] == 4'hE && log_w[0] && log_d[0] == 4'h4 && !log_w[1],
          "R4 handshake first", log_d[0], 4);
      chk(low_at_done >= GAP, "R8 ce low before done", low_at_done, GAP);
      wtime = '0;
      run_op(1, 0, gd);
      chk(rtime == VEC[v], "R6 read back", rtime, VEC[v]);
      nfield = 0;
      for (int k = 0; k < 13; k++)
        if (log_a[k + 2] != ORD[k] || log_w[k + 2]) nfield++;
      chk(nfield == 0, "R5 read order", nfield, 0);
    end

    // R6 direct preload with distinct tens/units
    for (int k = 0; k < 13; k++) mem[ORD[k]] = 4'(k + 1);
    run_op(1, 0, gd);
    chk(rtime == 52'hD_CB_A9_87_65_43_21, "R6 preload assembly", rtime,
        52'hD_CB_A9_87_65_43_21);

    // R4 busy retries
    busy_left = 3;
    run_op(1, 0, gd);
    nctl4 = 0;
    for (int i = 0; i < log_n; i++)
      if (log_w[i] && log_a[i] == 4'hE && log_d[i] == 4'h4) nctl4++;
    chk(nctl4 == 4, "R4 handshake repeats", nctl4, 4);
    chk(min_low >= GAP, "R4 ce gap between tries", min_low, GAP);
    chk(!err && rtime == 52'hD_CB_A9_87_65_43_21, "R4 read after retries",
        rtime, 52'hD_CB_A9_87_65_43_21);

    // R9 boundary: MAXT-1 busy still succeeds
    busy_left = MAXT - 1;
    run_op(1, 0, gd);
    chk(gd && !err && log_n == 2 * MAXT + 13, "R9 last retry succeeds",
        log_n, 2 * MAXT + 13);
    // R9 limit reached
    busy_left = MAXT;
    for (int k = 0; k < 13; k++) mem[ORD[k]] = 4'h9;
    run_op(1, 0, gd);
    chk(gd && err, "R9 error flag", {gd, err}, 2'b11);
    chk(log_n == 2 * MAXT, "R9 no field transfer", log_n, 2 * MAXT);
    chk(rtime == 52'hD_CB_A9_87_65_43_21, "R9 rtime kept", rtime,
        52'hD_CB_A9_87_65_43_21);
    busy_left = 0;
    run_op(1, 0, gd);
    chk(!err && rtime == 52'h9_99_99_99_99_99_99, "R9 err cleared", err, 0);

    // R10 request while busy ignored
    log_n = 0;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    repeat (10) @(negedge clk);
    wtime = 52'h1_11_11_11_11_11_11;
    wr_req = 1; @(negedge clk); wr_req = 0;
    wait_idle();
    repeat (60) @(negedge clk);
    chk(!busy && log_n == 15, "R10 busy request ignored", log_n, 15);
    chk(mem[0] == 4'h9, "R10 no write happened", mem[0], 9);
    // R10 simultaneous: read wins
    run_op(1, 1, gd);
    nfield = 0;
    for (int i = 0; i < log_n; i++) if (log_w[i] && log_a[i] != 4'hE) nfield++;
    chk(nfield == 0 && mem[0] == 4'h9, "R10 read priority", nfield, 0);

    // R3 oscillator stop at start-up
    for (int i = 0; i < 16; i++) mem[i] = 4'h5;
    xstp = 1; busy_left = 2;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    log_n = 0;
    rst_n = 1;
    @(negedge clk);
    wait_idle();
    chk(log_w[1] && log_a[1] == 4'h7 && log_d[1] == 4'h0, "R3 interval cleared",
        {log_a[1], log_d[1]}, 8'h70);
    chk(log_w[2] && log_a[2] == 4'hE && log_d[2] == 4'h7, "R3 adjust write",
        {log_a[2], log_d[2]}, 8'hE7);
    nfield = 0;
    for (int k = 0; k < 13; k++)
      if (mem[ORD[k]] != ((k == 6 || k == 8) ? 4'h1 : 4'h0)) nfield++;
    chk(nfield == 0 && mem[7] == 4'h0, "R3 default date", nfield, 0);
    chk(mem[14] == 4'h4 && !err, "R3 handshake then idle", mem[14], 4);

    finish_run();
  end
endmodule